// File: doc/BRIEF.md
# Handshaked Transposed-Form Four-Tap FIR Filter

This block is a four-tap finite impulse response filter in transposed direct form. Each accepted 8-bit unsigned sample goes to four multipliers at once, one for each coefficient. The four products then enter a chain of adders with a register between each adder and the next. Each multiplier is an iterative shift-and-add unit that retires one multiplier bit per clock. A sample therefore takes several cycles to turn into products, and the block takes samples through a valid/ready handshake. Once a sample is accepted, `in_ready` stays low until all four products are ready and the chain has moved one step.

A small controller has three named states. `S_IDLE` waits for a sample with `in_ready` high. The transition ACCEPT (`in_valid` high in `S_IDLE`) starts all multipliers and enters `S_BUSY`. `S_BUSY` holds until every multiplier reports done. The transition UPDATE then shifts the adder chain, registers the new output and enters `S_EMIT`. `S_EMIT` lasts one cycle, pulses `out_valid` with `in_ready` high again, and takes ACCEPT or falls back to `S_IDLE`. The coefficients come from a 32-bit port and are latched by the multipliers when a sample is accepted.

Top module: `fir4_transposed`

## Requirements
- R1: A synchronous active-high `rst` sets `in_ready` to 1, `out_valid` to 0 and `out_data` to 0, and clears every delay register. The outputs after reset therefore treat all earlier samples as zero.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which that sample's output is presented.
- R3: Each accepted sample produces exactly one `out_valid` pulse, one cycle wide. The pulse arrives DATA_W+1 (9) rising edges after the acceptance edge, and `in_ready` is 1 in the pulse cycle.
- R4: With unsigned coefficient h[k] held in `coef[8k+7:8k]`, the output for sample n is `out_data` = sum over k=0..3 of h[k]·x[n−k]. The three delayed terms use the three previously accepted samples.
- R5: Sums wrap modulo 2^16. With every coefficient at 255 and every sample at 255, the fourth output after reset is 63492.
- R6: `coef` is sampled on the acceptance edge. Changing it while `in_ready` is 0 has no effect on that sample's output.
- R7: `in_valid` and `in_data` are ignored while `in_ready` is 0. The ignored data never enters the filter history.
- R8: `out_data` holds its value in every cycle where `out_valid` is 0.
- R9: The filter history moves only on accepted samples. Idle gaps of any length between samples do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_data | input | 8 | Unsigned input sample |
| in_ready | output | 1 | Block can take a sample |
| coef | input | 32 | Four unsigned coefficients, h[k] at bits [8k+7:8k] |
| out_valid | output | 1 | One-cycle pulse: new output on out_data |
| out_data | output | 16 | Filter output, modulo 2^16 |

## Verification
The hardest case to reach from the ports is activity during the multiply window. This means a second sample offered, or the coefficient word changed, while the multipliers are still working. Only those cycles can show that the history and the products are protected. The bench drives `in_valid` high with different data, and rewrites `coef`, on chosen cycles between acceptance and the output pulse. It then compares the result with the value predicted from the accepted samples alone. A back-to-back sample offered in the pulse cycle itself checks that acceptance from `S_EMIT` loses nothing.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUSY = 2'd1,
        S_EMIT = 2'd2
    } fir_state_t;
endpackage

// File: rtl/fir4_shift_add_mul.sv
module fir4_shift_add_mul #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int P_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [A_W-1:0] mcand,
    input  logic [B_W-1:0] mplier,
    output logic [P_W-1:0] product,
    output logic           done
);
    localparam int CNT_W = $clog2(B_W + 1);

    logic [P_W-1:0]   acc_q;
    logic [P_W-1:0]   mc_q;
    logic [B_W-1:0]   mp_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            cnt_q <= '0;
            done  <= 1'b1;
        end else if (start) begin
            acc_q <= '0;
            mc_q  <= {{(P_W-A_W){1'b0}}, mcand};
            mp_q  <= mplier;
            cnt_q <= CNT_W'(B_W);
            done  <= 1'b0;
        end else if (!done) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                done <= 1'b1;
            end
        end
    end

    assign product = acc_q;
endmodule

// File: rtl/fir4_transposed.sv
module fir4_transposed
    import fir4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 16,
    parameter int NTAPS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    in_ready,
    input  logic [NTAPS*COEF_W-1:0] coef,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        out_data
);
    localparam int LAST = NTAPS - 1;

    fir_state_t state_q, state_d;
    logic [NTAPS-1:0] mul_done;
    logic [ACC_W-1:0] prod [NTAPS];
    logic [ACC_W-1:0] dly_q [NTAPS];
    logic             accept;
    logic             update;

    assign in_ready = (state_q == S_IDLE) || (state_q == S_EMIT);
    assign accept   = in_valid && in_ready;
    assign update   = (state_q == S_BUSY) && (&mul_done);

    genvar k;
    generate
        for (k = 0; k < NTAPS; k++) begin : g_tap
            fir4_shift_add_mul #(
                .A_W (COEF_W),
                .B_W (DATA_W),
                .P_W (ACC_W)
            ) i_mul (
                .clk     (clk),
                .rst     (rst),
                .start   (accept),
                .mcand   (coef[k*COEF_W +: COEF_W]),
                .mplier  (in_data),
                .product (prod[k]),
                .done    (mul_done[k])
            );

            if (k == LAST) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        dly_q[k] <= '0;
                    end else if (update) begin
                        dly_q[k] <= prod[k];
                    end
                end
            end else begin : g_link
                always_ff @(posedge clk) begin
                    if (rst) begin
                        dly_q[k] <= '0;
                    end else if (update) begin
                        dly_q[k] <= prod[k] + dly_q[k+1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_BUSY;
            S_BUSY:  if (update) state_d = S_EMIT;
            S_EMIT:  state_d = accept ? S_BUSY : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign out_valid = (state_q == S_EMIT);
    assign out_data  = dly_q[0];
endmodule

// File: rtl/fir4_checker.sv
module fir4_checker #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid && out_data == '0)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R3

    AST_PULSE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready); // R3

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (out_valid || $stable(out_data))); // R8
endmodule

bind fir4_transposed fir4_checker #(.ACC_W(ACC_W)) i_fir4_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_fir4_transposed.sv
module test_fir4_transposed;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic [31:0] coef;
    logic        out_valid;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int hist [4];

    always #5 clk = ~clk;

    fir4_transposed i_fir4_transposed (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .coef      (coef),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // {sample, expected y} for h0..h3 = 1,2,3,4 from reset
    localparam logic [23:0] VEC [9] = '{
        {8'd10, 16'd10}, {8'd20, 16'd40}, {8'd30, 16'd100},
        {8'd40, 16'd200}, {8'd0, 16'd250}, {8'd0, 16'd240},
        {8'd0, 16'd160}, {8'd0, 16'd0},   {8'd5, 16'd5}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input logic [31:0] c, input int x);
        int s;
        hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = x;
        s = 0;
        for (int k = 0; k < 4; k++) s += int'(c[8*k +: 8]) * hist[k];
        return s % 65536;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) hist[k] = 0;
    endtask

    // mode 0: plain; 1: inject busy in_valid with junk; 2: change coef while busy
    task automatic send(input int x, input int mode, input string req, output int y);
        int lat;
        logic [31:0] c_acc;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = 8'(x);
        c_acc = coef;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 60) begin
            if (lat == 2) check("R2", int'(in_ready), 0);
            if (mode == 1 && lat == 3) begin in_valid = 1'b1; in_data = 8'hA5; end
            if (mode == 1 && lat == 5) in_valid = 1'b0;
            if (mode == 2 && lat == 3) coef = 32'hFFFF_FFFF;
            @(negedge clk);
            lat++;
        end
        in_valid = 1'b0;
        check("R3", lat - 1, 9);
        check("R3", int'(in_ready), 1);
        y = int'(out_data);
        check(req, y, model(c_acc, x));
        if (mode == 2) coef = c_acc;
        @(negedge clk);
        check("R3", int'(out_valid), 0);
        check("R8", int'(out_data), y);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int y;
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        coef = {8'd4, 8'd3, 8'd2, 8'd1};
        do_reset();
        check("R1", int'(in_ready), 1);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_data), 0);

        // R4 table walk
        foreach (VEC[i]) begin
            send(int'(VEC[i][23:16]), 0, "R4", y);
            check("R4", y, int'(VEC[i][15:0]));
        end

        // R7: busy-time offers ignored
        send(7, 1, "R7", y);
        send(9, 0, "R7", y);
        // R6: coef change while busy ignored
        send(11, 2, "R6", y);
        send(13, 0, "R6", y);
        // R9: idle gap does not move history
        repeat (40) @(negedge clk);
        check("R8", int'(out_data), y);
        send(17, 0, "R9", y);

        // R1: reset mid-stream clears history
        do_reset();
        check("R1", int'(out_data), 0);
        send(50, 0, "R1", y);
        check("R1", y, 50);

        // R5: wrap
        coef = 32'hFFFF_FFFF;
        do_reset();
        for (int i = 0; i < 4; i++) send(255, 0, "R5", y);
        check("R5", y, 63492);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule